// File: doc/BRIEF.md
# Serial flash status register write controller

This block holds the status register of a serial flash slave and decides whether software may change it. It watches a single-bit SPI command stream (clock mode 0, chip select active low, most significant bit first) and acts on three opcodes: a write-enable command that arms a write enable latch, a write-status command that carries a new status byte, and a read-status command that shifts the status byte back out. The SPI pins and the write-protect pin are synchronized into the system clock domain. All decisions are made on system clock edges.

A status write is accepted only when the latch is armed. It is also refused when the write-disable bit is set while the write-protect pin is held low. Refusal in that case is the hardware-protected state. An accepted write updates the protection fields at once and starts a self-timed busy period. The length of that period is the parameter `WCYC`, counted in system clocks. Once the period ends, the busy flag drops and the latch is cleared. The status byte can be read back over SPI at any time, including during the busy period, so a host can poll for completion.

The status byte is laid out as follows: bit 7 write-disable, bit 6 always 0, bit 5 top/bottom select, bits 4..2 block protect, bit 1 write enable latch, bit 0 busy.

Top module: `sr_wr_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and `spi_miso_oe` is 0.
- R2: A frame of exactly 8 bits with opcode 0x06 sets the write enable latch (status bit 1).
- R3: A frame of exactly 16 bits, opcode 0x01 followed by a data byte, copies data bits 7, 5 and 4..2 into the status register when the write is allowed. Data bits 6, 1 and 0 have no effect. The same frame sets the busy bit (status bit 0). The `wr_dis`, `top_bot` and `blk_prot` outputs equal status bits 7, 5 and 4..2.
- R4: A write-status frame sent while the latch is 0 changes nothing and does not start a busy period.
- R5: With write-disable at 1 and `wp_n` low, a write-status frame is rejected. The fields stay unchanged, no busy period starts and the latch stays 1.
- R6: With write-disable at 1 and `wp_n` high, a write-status frame with the latch set is accepted.
- R7: With write-disable at 0, a write-status frame with the latch set is accepted even while `wp_n` is low.
- R8: The busy bit stays 1 for exactly `WCYC` system clocks. When it falls, the write enable latch is cleared.
- R9: A frame starting with opcode 0x05 returns the status byte on `spi_miso`, MSB first, one bit per SPI clock, starting at the ninth clock. The byte repeats and is re-sampled at each byte boundary. This also works during a busy period. `spi_miso_oe` is 1 only in that read data phase, so it stays 0 throughout any write-status frame.
- R10: Write-enable frames of other than 8 bits and write-status frames of other than 16 bits are ignored.
- R11: During a busy period, write-status frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data into the block |
| wp_n | input | 1 | Write-protect pin, active low |
| spi_miso | output | 1 | SPI data out of the block |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| status | output | 8 | Current status byte |
| blk_prot | output | 3 | Block protect field |
| top_bot | output | 1 | Top/bottom select |
| wr_dis | output | 1 | Status register write-disable bit |

## Verification
The busy countdown and the SPI command path can act in the same busy window. The bench provokes this by sending a read-status frame and then a second write-status frame while the counter is running. The read must return two bytes that both show busy and the latch set. The second write must leave no trace once the busy period ends. The busy length is measured at the `status` port and compared with `WCYC`, so a command that restarts or stretches the count is also caught.

// File: rtl/sr_wr_pkg.sv
package sr_wr_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDSR = 8'h05;

  typedef struct packed {
    logic       srwd;
    logic       rsv;
    logic       tb;
    logic [2:0] bp;
    logic       wel;
    logic       wip;
  } status_t;
endpackage

// File: rtl/sr_wr_sync.sv
module sr_wr_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else        stg[g] <= src;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sr_wr_rx.sv
module sr_wr_rx #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_rise,
  input  logic             cs_fall,
  input  logic             mosi,
  output logic [CNT_W-1:0] cnt,
  output logic [15:0]      shreg
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_d;
  logic [15:0]      sh_d;

  always_comb begin
    cnt_d = cnt;
    sh_d  = shreg;
    if (cs_fall) begin
      cnt_d = '0;
    end else if (sck_rise) begin
      sh_d = {shreg[14:0], mosi};
      if (cnt != CNT_MAX) cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else begin
      cnt   <= cnt_d;
      shreg <= sh_d;
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && !cs_fall && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R10
endmodule

// File: rtl/sr_wr_tx.sv
module sr_wr_tx
  import sr_wr_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic [CNT_W-1:0] cnt,
  input  logic [6:0]       sh_low,
  input  logic             mosi,
  input  logic [7:0]       status,
  output logic             miso,
  output logic             miso_oe
);
  localparam logic [CNT_W-1:0] LAST_OP_BIT = CNT_W'(7);

  logic       rd_q, rd_d;
  logic [2:0] idx_q, idx_d;
  logic [7:0] snap_q, snap_d;
  logic       miso_d;

  always_comb begin
    rd_d   = rd_q;
    idx_d  = idx_q;
    snap_d = snap_q;
    miso_d = miso;
    if (cs_fall || cs_rise) begin
      rd_d  = 1'b0;
      idx_d = '0;
    end else if (sck_rise && cnt == LAST_OP_BIT && {sh_low, mosi} == OP_RDSR) begin
      rd_d  = 1'b1;
      idx_d = '0;
    end else if (sck_fall && rd_q) begin
      if (idx_q == 3'd0) begin
        snap_d = status;
        miso_d = status[7];
      end else begin
        miso_d = snap_q[3'd7 - idx_q];
      end
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      idx_q  <= '0;
      snap_q <= '0;
      miso   <= 1'b0;
    end else begin
      rd_q   <= rd_d;
      idx_q  <= idx_d;
      snap_q <= snap_d;
      miso   <= miso_d;
    end
  end

  assign miso_oe = rd_q;

  AST_OE_OFF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !miso_oe); // R9
endmodule

// File: rtl/sr_wr_core.sv
module sr_wr_core
  import sr_wr_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int WCYC  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_rise,
  input  logic [CNT_W-1:0] cnt,
  input  logic [15:0]      shreg,
  input  logic             wp_n,
  output status_t          sts
);
  localparam int            TMR_W   = (WCYC > 2) ? $clog2(WCYC) : 1;
  localparam logic [TMR_W-1:0] TMR_MAX = TMR_W'(WCYC - 1);
  localparam logic [CNT_W-1:0] LEN_EN = CNT_W'(8);
  localparam logic [CNT_W-1:0] LEN_WR = CNT_W'(16);

  status_t          sts_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             wren_hit, wrsr_hit, wr_ok;

  assign wren_hit = cs_rise && cnt == LEN_EN && shreg[7:0]  == OP_WREN;
  assign wrsr_hit = cs_rise && cnt == LEN_WR && shreg[15:8] == OP_WRSR;
  assign wr_ok    = sts.wel && !(sts.srwd && !wp_n);

  always_comb begin
    sts_d     = sts;
    sts_d.rsv = 1'b0;
    tmr_d     = tmr_q;
    if (sts.wip) begin
      if (tmr_q == TMR_MAX) begin
        sts_d.wip = 1'b0;
        sts_d.wel = 1'b0;
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end else if (wren_hit) begin
      sts_d.wel = 1'b1;
    end else if (wrsr_hit && wr_ok) begin
      sts_d.srwd = shreg[7];
      sts_d.tb   = shreg[5];
      sts_d.bp   = shreg[4:2];
      sts_d.wip  = 1'b1;
      tmr_d      = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts   <= '0;
      tmr_q <= '0;
    end else begin
      sts   <= sts_d;
      tmr_q <= tmr_d;
    end
  end

  AST_WREN_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wren_hit && !sts.wip) |=> sts.wel); // R2
  AST_NO_LATCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_hit && !sts.wel && !sts.wip) |=> (!sts.wip && $stable(sts))); // R4
  AST_HW_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_hit && sts.srwd && !wp_n && !sts.wip) |=> (!sts.wip && $stable(sts))); // R5
  AST_END_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts.wip) |-> !sts.wel); // R8
  AST_BUSY_LOCKS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sts.wip && wrsr_hit) |=> ($stable(sts.bp) && $stable(sts.tb) && $stable(sts.srwd))); // R11
  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q <= TMR_MAX); // R8
endmodule

// File: rtl/sr_wr_ctrl.sv
module sr_wr_ctrl
  import sr_wr_pkg::*;
#(
  parameter int WCYC      = 64,
  parameter int SYNC_STGS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  input  logic       wp_n,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  output logic [7:0] status,
  output logic [2:0] blk_prot,
  output logic       top_bot,
  output logic       wr_dis
);
  localparam int CNT_W = 5;

  logic       rst_s_n;
  logic [3:0] pins_s;
  logic       sck_s, cs_s, mosi_s, wp_s;
  logic       sck_q, cs_q;
  logic       sck_rise, sck_fall, cs_rise, cs_fall;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      shreg;
  status_t          sts;

  sr_wr_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_s_n));

  sr_wr_sync #(.WIDTH(4), .STAGES(SYNC_STGS), .RST_VAL(4'b1100)) u_pin_sync (
    .clk(clk), .rst_n(rst_s_n), .d({wp_n, spi_cs_n, spi_sck, spi_mosi}), .q(pins_s));

  assign {wp_s, cs_s, sck_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  assign sck_rise = sck_s && !sck_q && !cs_s;
  assign sck_fall = !sck_s && sck_q && !cs_s;
  assign cs_fall  = !cs_s && cs_q;
  assign cs_rise  = cs_s && !cs_q;

  sr_wr_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_s_n), .sck_rise(sck_rise), .cs_fall(cs_fall),
    .mosi(mosi_s), .cnt(cnt), .shreg(shreg));

  sr_wr_core #(.CNT_W(CNT_W), .WCYC(WCYC)) u_core (
    .clk(clk), .rst_n(rst_s_n), .cs_rise(cs_rise), .cnt(cnt), .shreg(shreg),
    .wp_n(wp_s), .sts(sts));

  sr_wr_tx #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_s_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .cnt(cnt), .sh_low(shreg[6:0]),
    .mosi(mosi_s), .status(sts), .miso(spi_miso), .miso_oe(spi_miso_oe));

  assign status   = sts;
  assign blk_prot = sts.bp;
  assign top_bot  = sts.tb;
  assign wr_dis   = sts.srwd;
endmodule

// File: tb/sr_wr_ctrl_bench.sv
module sr_wr_ctrl_bench;
  localparam int WCYC = 1500;
  localparam int H    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso, miso_oe, top_bot, wr_dis;
  logic [7:0] status;
  logic [2:0] blk_prot;

  always #2 clk = ~clk;

  sr_wr_ctrl #(.WCYC(WCYC)) u_sr_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .wp_n(wp_n), .spi_miso(miso), .spi_miso_oe(miso_oe), .status(status),
    .blk_prot(blk_prot), .top_bot(top_bot), .wr_dis(wr_dis));

  typedef struct { string tag; logic [15:0] val; } exp_t;
  exp_t        sbq[$];
  int          n_run = 0, n_fail = 0;
  logic [15:0] obs;
  event        obs_ev;
  bit          done = 0;

  always @(obs_ev) begin
    exp_t e;
    n_run++;
    if (sbq.size() == 0) begin
      n_fail++;
      $display("FAIL scoreboard empty: actual %h expected none", obs);
    end else begin
      e = sbq.pop_front();
      if (obs !== e.val) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", e.tag, obs, e.val);
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    sbq.push_back('{tag, exp});
    obs = act;
    ->obs_ev;
    #1;
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic oe_seen = 1'b0;
  always @(posedge clk) if (miso_oe) oe_seen <= 1'b1;

  int busy_run = 0, busy_len = 0;
  always @(posedge clk) begin
    if (status[0]) busy_run <= busy_run + 1;
    else if (busy_run != 0) begin
      busy_len <= busy_run;
      busy_run <= 0;
    end
  end

  task automatic spi(input logic [31:0] bits, input int n, output logic [15:0] rx);
    rx = '0;
    cs_n = 1'b0;
    wclk(H);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = bits[i];
      wclk(H);
      if (n - 1 - i >= 8) rx = {rx[14:0], miso};
      sck = 1'b1;
      wclk(H);
      sck = 1'b0;
    end
    wclk(H);
    cs_n = 1'b1;
    mosi = 1'b0;
    wclk(12);
  endtask

  task automatic wren();
    logic [15:0] rx;
    spi(32'h06, 8, rx);
  endtask

  task automatic wrsr(input logic [7:0] d);
    logic [15:0] rx;
    spi({16'h0, 8'h01, d}, 16, rx);
  endtask

  task automatic wait_idle();
    int k = 0;
    while (status[0] && k < 4 * WCYC) begin wclk(1); k++; end
    wclk(4);
  endtask

  initial begin
    #700000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rx;
    wclk(5);
    rst_n = 1'b1;
    wclk(10);
    check("R1 reset status", {8'h0, status}, 16'h0000);
    check("R1 reset miso_oe", {15'h0, miso_oe}, 16'h0000);

    wrsr(8'hBC);
    check("R4 write without latch", {8'h0, status}, 16'h0000);

    spi(32'h03, 7, rx);
    check("R10 write-enable of 7 bits", {8'h0, status}, 16'h0000);
    spi(32'h0C, 9, rx);
    check("R10 write-enable of 9 bits", {8'h0, status}, 16'h0000);
    wren();
    check("R2 latch set", {8'h0, status}, 16'h0002);

    spi({17'h0, 8'h01, 7'h7F}, 15, rx);
    check("R10 write-status of 15 bits", {8'h0, status}, 16'h0002);
    spi({15'h0, 8'h01, 8'hFF, 1'b0}, 17, rx);
    check("R10 write-status of 17 bits", {8'h0, status}, 16'h0002);

    wp_n = 1'b0;
    oe_seen = 1'b0;
    wrsr(8'hFF);
    check("R7 accepted with wp low, R3 bit6 ignored", {8'h0, status}, 16'h00BF);
    check("R9 no output enable during write frame", {15'h0, oe_seen}, 16'h0000);
    spi({8'h05, 16'h0}, 24, rx);
    check("R9 read two bytes while busy", rx, 16'hBFBF);
    wrsr(8'h00);
    wait_idle();
    check("R11 write ignored while busy", {8'h0, status}, 16'h00BC);
    check("R8 busy length", busy_len[15:0], 16'(WCYC));
    check("R3 field outputs", {8'h0, wr_dis, 1'b0, top_bot, blk_prot, 2'b00}, 16'h00BC);

    wren();
    wrsr(8'h00);
    wclk(20);
    check("R5 hardware protected reject", {8'h0, status}, 16'h00BE);
    spi({8'h05, 8'h0}, 16, rx);
    check("R9 read idle", rx, 16'h00BE);
    check("R9 output enable off after read", {15'h0, miso_oe}, 16'h0000);

    wp_n = 1'b1;
    wrsr(8'h24);
    check("R6 accepted with wp high", {8'h0, status}, 16'h0027);
    wait_idle();
    check("R8 latch cleared at end", {8'h0, status}, 16'h0024);
    check("R3 field outputs tb/bp", {8'h0, wr_dis, 1'b0, top_bot, blk_prot, 2'b00}, 16'h0024);

    wp_n = 1'b0;
    wren();
    wrsr(8'h43);
    check("R3 bits 6,1,0 ignored", {8'h0, status}, 16'h0003);
    wait_idle();
    check("R7 final state", {8'h0, status}, 16'h0000);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule